// File: doc/BRIEF.md
# Edge-Interrupt GPIO Bank

This block is a register-mapped controller for a bank of up to 64 general-purpose pins. Each pin has an output-enable bit and an output-drive bit. The synchronized level of the pin can be read back. Each pin also has an edge-capture interrupt path, with a per-pin enable, an edge polarity, a latched pending flag and a wake mask. Software reaches the registers over a simple single-cycle bus with 32-bit words. Every register is split into two words: the low word covers pins 0 to 31, and the word 4 bytes above it covers pins 32 to 63.

The block drives two summary lines. The interrupt line is raised for pending flags that are enabled. The wake line is raised for pending flags selected by the wake mask. Pin levels pass through a two-stage synchronizer. Edges are found by comparing the synchronized level with the level one cycle earlier. A captured edge stays latched until software writes a one to its pending bit.

The register windows are as follows. The pin window holds direction at 0x00, level at 0x10 and drive at 0x18. The interrupt window holds enable at 0x40, polarity at 0x48, pending at 0x50 and wake mask at 0x58. Each offset is the low word of its register; the high word is 4 bytes above it.

Top module: `gpio_edge_bank`

## Requirements
- R1: After a synchronous reset, the following are all zero: every direction, drive, enable, polarity, wake-mask and pending bit, and the outputs pin_oe, pin_out, irq and wake.
- R2: Writing the direction register (0x00, high word 0x04) sets pin_oe. Pin n uses bit n mod 32 of word n/32, and a 1 makes the pin an output. The new value shows on pin_oe after the write edge and reads back unchanged.
- R3: Writing the drive register (0x18, high word 0x1C) sets pin_out after the write edge, with the same bit mapping as R2. The value reads back unchanged.
- R4: The level register (0x10, high word 0x14) returns pin_in after a two-flop synchronizer. Writes to it have no effect.
- R5: With polarity bit 0 (register 0x48/0x4C), a rising edge sets the pending bit (0x50/0x54); with polarity bit 1, a falling edge sets it. The pending bit is set on the third clock edge after the pin changes. An edge of the opposite sense sets nothing.
- R6: Writing a 1 to a pending bit clears it. Writing a 0 leaves it unchanged. An edge captured on the same clock edge as a clear of that bit leaves the bit set.
- R7: irq is high one cycle after some pending bit has its enable bit (0x40/0x44) set. Otherwise irq is low.
- R8: wake is high one cycle after some pending bit has its wake-mask bit (0x58/0x5C) set, whatever the enable bits hold. Otherwise wake is low.
- R9: Register bits at or above NUM_PINS read as zero and ignore writes. Offsets outside the map read as zero.
- R10: bus_rdata carries the addressed word in the cycle after bus_rd is high. At all other times it is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 5 | Byte address bits 6..2 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | NUM_PINS | Asynchronous pin levels |
| pin_oe | output | NUM_PINS | Output enable per pin |
| pin_out | output | NUM_PINS | Drive value per pin |
| irq | output | 1 | Combined enabled-interrupt line |
| wake | output | 1 | Combined wake request line |

## Verification
Edge capture and the write-one-to-clear path can act on the same pending bit in the same cycle. The bench provokes this by raising a pin at a known negative edge. It then schedules the clearing bus write so that its active edge is exactly the third clock edge after the pin change, the edge on which the synchronized rising edge is captured. It then reads the pending register and expects the bit still set. A second clear issued one cycle later must remove the bit, which shows that the surviving bit came from the collision and not from a clear that had no effect.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned ADDR_W = 7;
  localparam int unsigned PAD_W  = 2 * WORD_W;

  localparam logic [ADDR_W-1:0] OFS_DIR  = 7'h00;
  localparam logic [ADDR_W-1:0] OFS_LVL  = 7'h10;
  localparam logic [ADDR_W-1:0] OFS_DRV  = 7'h18;
  localparam logic [ADDR_W-1:0] OFS_IEN  = 7'h40;
  localparam logic [ADDR_W-1:0] OFS_EDG  = 7'h48;
  localparam logic [ADDR_W-1:0] OFS_PEND = 7'h50;
  localparam logic [ADDR_W-1:0] OFS_WMSK = 7'h58;
endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int W      = 36,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) stg <= '0;
    else     stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_bank_edge.sv
module gpio_bank_edge #(
  parameter int W = 36
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] clr,
  input  logic [W-1:0] ien,
  input  logic [W-1:0] wmsk,
  output logic [W-1:0] lvl_d,
  output logic [W-1:0] pend,
  output logic         irq,
  output logic         wake
);
  logic [W-1:0] hit;

  // rising edges when polarity is 0, falling edges when it is 1
  always_comb hit = (lvl & ~lvl_d & ~pol) | (~lvl & lvl_d & pol);

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_d <= '0;
      pend  <= '0;
      irq   <= 1'b0;
      wake  <= 1'b0;
    end else begin
      lvl_d <= lvl;
      pend  <= (pend & ~clr) | hit;   // capture beats clear
      irq   <= |(pend & ien);
      wake  <= |(pend & wmsk);
    end
  end
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 36
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:2]   bus_addr,
  input  logic [WORD_W-1:0]   bus_wdata,
  output logic [WORD_W-1:0]   bus_rdata,
  input  logic [NUM_PINS-1:0] level,
  input  logic [NUM_PINS-1:0] pend,
  output logic [NUM_PINS-1:0] dir_q,
  output logic [NUM_PINS-1:0] drv_q,
  output logic [NUM_PINS-1:0] ien_q,
  output logic [NUM_PINS-1:0] pol_q,
  output logic [NUM_PINS-1:0] wmsk_q,
  output logic [NUM_PINS-1:0] clr
);
  localparam logic [PAD_W-1:0] PIN_MASK = {PAD_W{1'b1}} >> (PAD_W - NUM_PINS);

  logic [ADDR_W-1:0] base;
  logic              hi;
  logic [PAD_W-1:0]  dir_r, drv_r, ien_r, pol_r, wmsk_r;
  logic [PAD_W-1:0]  clr_pad, sel;
  logic [WORD_W-1:0] word;

  assign base = {bus_addr[ADDR_W-1:3], 3'b000};
  assign hi   = bus_addr[2];

  function automatic logic [PAD_W-1:0] merge(input logic [PAD_W-1:0] old,
                                             input logic h,
                                             input logic [WORD_W-1:0] d);
    logic [PAD_W-1:0] n;
    n = old;
    if (h) n[PAD_W-1:WORD_W] = d;
    else   n[WORD_W-1:0]     = d;
    return n & PIN_MASK;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_r  <= '0;
      drv_r  <= '0;
      ien_r  <= '0;
      pol_r  <= '0;
      wmsk_r <= '0;
    end else if (bus_wr) begin
      case (base)
        OFS_DIR:  dir_r  <= merge(dir_r,  hi, bus_wdata);
        OFS_DRV:  drv_r  <= merge(drv_r,  hi, bus_wdata);
        OFS_IEN:  ien_r  <= merge(ien_r,  hi, bus_wdata);
        OFS_EDG:  pol_r  <= merge(pol_r,  hi, bus_wdata);
        OFS_WMSK: wmsk_r <= merge(wmsk_r, hi, bus_wdata);
        default: ;
      endcase
    end
  end

  always_comb begin
    clr_pad = '0;
    if (bus_wr && base == OFS_PEND) clr_pad = merge('0, hi, bus_wdata);
  end

  always_comb begin
    case (base)
      OFS_DIR:  sel = dir_r;
      OFS_LVL:  sel = PAD_W'(level);
      OFS_DRV:  sel = drv_r;
      OFS_IEN:  sel = ien_r;
      OFS_EDG:  sel = pol_r;
      OFS_PEND: sel = PAD_W'(pend);
      OFS_WMSK: sel = wmsk_r;
      default:  sel = '0;
    endcase
    word = hi ? sel[PAD_W-1:WORD_W] : sel[WORD_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= word;
    else             bus_rdata <= '0;
  end

  assign dir_q  = dir_r[NUM_PINS-1:0];
  assign drv_q  = drv_r[NUM_PINS-1:0];
  assign ien_q  = ien_r[NUM_PINS-1:0];
  assign pol_q  = pol_r[NUM_PINS-1:0];
  assign wmsk_q = wmsk_r[NUM_PINS-1:0];
  assign clr    = clr_pad[NUM_PINS-1:0];
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS    = 36,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:2]   bus_addr,
  input  logic [WORD_W-1:0]   bus_wdata,
  output logic [WORD_W-1:0]   bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic [NUM_PINS-1:0] pin_out,
  output logic                irq,
  output logic                wake
);
  logic [NUM_PINS-1:0] lvl_w, lvl_d_w, pend_w, clr_w, ien_w, pol_w, wmsk_w;

  gpio_bank_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) sync_i (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (lvl_w)
  );

  gpio_bank_regs #(.NUM_PINS(NUM_PINS)) regs_i (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .level     (lvl_w),
    .pend      (pend_w),
    .dir_q     (pin_oe),
    .drv_q     (pin_out),
    .ien_q     (ien_w),
    .pol_q     (pol_w),
    .wmsk_q    (wmsk_w),
    .clr       (clr_w)
  );

  gpio_bank_edge #(.W(NUM_PINS)) edge_i (
    .clk   (clk),
    .rst   (rst),
    .lvl   (lvl_w),
    .pol   (pol_w),
    .clr   (clr_w),
    .ien   (ien_w),
    .wmsk  (wmsk_w),
    .lvl_d (lvl_d_w),
    .pend  (pend_w),
    .irq   (irq),
    .wake  (wake)
  );
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int N = 36
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] pin_oe,
  input logic [N-1:0] pin_out,
  input logic [N-1:0] lvl,
  input logic [N-1:0] lvl_d,
  input logic [N-1:0] pend,
  input logic [N-1:0] clr,
  input logic [N-1:0] ien,
  input logic [N-1:0] wmsk,
  input logic         irq,
  input logic         wake
);
  a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pin_oe == '0 && pin_out == '0 && pend == '0 && !irq && !wake));

  // a pending bit only appears where the synchronized level changed
  a_r5_set_needs_edge: assert property (@(posedge clk) disable iff (rst)
    ((pend & ~$past(pend)) & ~$past(lvl ^ lvl_d)) == '0);

  // a pending bit only disappears where a clear was written
  a_r6_clear_only_by_write: assert property (@(posedge clk) disable iff (rst)
    (($past(pend) & ~$past(clr)) & ~pend) == '0);

  a_r7_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
    irq |-> |($past(pend & ien)));

  a_r8_wake_needs_mask: assert property (@(posedge clk) disable iff (rst)
    wake |-> |($past(pend & wmsk)));
endmodule

bind gpio_edge_bank gpio_bank_chk #(.N(NUM_PINS)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .pin_oe  (pin_oe),
  .pin_out (pin_out),
  .lvl     (lvl_w),
  .lvl_d   (lvl_d_w),
  .pend    (pend_w),
  .clr     (clr_w),
  .ien     (ien_w),
  .wmsk    (wmsk_w),
  .irq     (irq),
  .wake    (wake)
);

// File: tb/gpio_edge_bank_tb_top.sv
module gpio_edge_bank_tb_top;
  localparam int N = 36;
  localparam logic [63:0] MASK = (64'd1 << N) - 64'd1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [6:2]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [N-1:0]  pin_in = '0;
  logic [N-1:0]  pin_oe, pin_out;
  logic          irq, wake;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  gpio_edge_bank #(.NUM_PINS(N)) dut_i (
    .clk (clk), .rst (rst), .bus_wr (bus_wr), .bus_rd (bus_rd),
    .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
    .pin_in (pin_in), .pin_oe (pin_oe), .pin_out (pin_out),
    .irq (irq), .wake (wake)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int c);
    repeat (c) @(negedge clk);
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a[6:2]; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a[6:2];
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wr64(input logic [6:0] a, input logic [63:0] v);
    wr(a, v[31:0]);
    wr(a + 7'd4, v[63:32]);
  endtask

  task automatic rd64(input logic [6:0] a, output logic [63:0] v);
    logic [31:0] lo, hi;
    rd(a, lo);
    rd(a + 7'd4, hi);
    v = {hi, lo};
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    logic [31:0] w;
    logic [63:0] pats [3];
    pats[0] = 64'hFFFF_FFFF_FFFF_FFFF;
    pats[1] = 64'h5A5A_0F0F_A5A5_1234;
    pats[2] = 64'h0000_0009_8000_0001;

    idle(5);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    check("R1 pin_oe", 64'(pin_oe), 64'd0);
    check("R1 pin_out", 64'(pin_out), 64'd0);
    check("R1 irq/wake", {62'd0, irq, wake}, 64'd0);
    rd64(7'h00, v); check("R1 dir", v, 64'd0);
    rd64(7'h50, v); check("R1 pend", v, 64'd0);
    check("R10 idle rdata", 64'(bus_rdata), 64'd0);

    // R2 / R3 / R9 direction and drive
    for (int p = 0; p < 3; p++) begin
      wr64(7'h00, pats[p]);
      check("R2 pin_oe", 64'(pin_oe), pats[p] & MASK);
      rd64(7'h00, v); check("R2 R9 dir readback", v, pats[p] & MASK);
      wr64(7'h18, ~pats[p]);
      check("R3 pin_out", 64'(pin_out), ~pats[p] & MASK);
      rd64(7'h18, v); check("R3 R9 drive readback", v, ~pats[p] & MASK);
    end

    // R9 unmapped offsets
    rd(7'h20, w); check("R9 unmapped 0x20", 64'(w), 64'd0);
    rd(7'h34, w); check("R9 unmapped 0x34", 64'(w), 64'd0);
    rd(7'h60, w); check("R9 unmapped 0x60", 64'(w), 64'd0);

    // R4 synchronized level
    for (int p = 0; p < 3; p++) begin
      pin_in = pats[p][N-1:0];
      idle(3);
      rd64(7'h10, v); check("R4 level", v, pats[p] & MASK);
    end
    wr64(7'h10, 64'd0);
    rd64(7'h10, v); check("R4 level write ignored", v, pats[2] & MASK);

    // clean slate for edges
    pin_in = '0;
    idle(4);
    wr64(7'h50, 64'hFFFF_FFFF_FFFF_FFFF);
    rd64(7'h50, v); check("R6 clear all", v, 64'd0);

    // R5 rising sweep, polarity 0
    for (int n = 0; n < N; n++) begin
      logic [6:0] hw;
      hw = (n >= 32) ? 7'h54 : 7'h50;
      pin_in[n] = 1'b1;
      idle(4);
      rd64(7'h50, v); check("R5 rising capture", v, 64'd1 << n);
      wr(hw, 32'd0);
      rd64(7'h50, v); check("R6 write zero keeps", v, 64'd1 << n);
      wr(hw, 32'd1 << (n % 32));
      rd64(7'h50, v); check("R6 write one clears", v, 64'd0);
      pin_in[n] = 1'b0;
      idle(4);
      rd64(7'h50, v); check("R5 falling ignored at pol 0", v, 64'd0);
    end

    // R5 falling sweep, polarity 1
    wr64(7'h48, 64'hFFFF_FFFF_FFFF_FFFF);
    rd64(7'h48, v); check("R5 R9 polarity readback", v, MASK);
    pin_in = '1;
    idle(4);
    rd64(7'h50, v); check("R5 rising ignored at pol 1", v, 64'd0);
    for (int n = 0; n < N; n++) begin
      pin_in[n] = 1'b0;
      idle(4);
      rd64(7'h50, v); check("R5 falling capture", v, 64'd1 << n);
      wr64(7'h50, 64'd1 << n);
      pin_in[n] = 1'b1;
      idle(4);
      rd64(7'h50, v); check("R5 rising ignored after clear", v, 64'd0);
    end

    // R7 / R8 summary lines
    wr64(7'h48, 64'd0);
    pin_in = '0;
    idle(4);
    wr64(7'h50, 64'hFFFF_FFFF_FFFF_FFFF);
    pin_in[3] = 1'b1;
    idle(4);
    check("R7 irq off without enable", 64'(irq), 64'd0);
    check("R8 wake off without mask", 64'(wake), 64'd0);
    wr(7'h40, 32'd1 << 3);
    idle(2);
    check("R7 irq on with enable", 64'(irq), 64'd1);
    wr(7'h40, 32'd1 << 4);
    idle(2);
    check("R7 irq off other enable", 64'(irq), 64'd0);
    wr(7'h40, 32'd0);
    wr(7'h58, 32'd1 << 3);
    idle(2);
    check("R8 wake without enable", 64'(wake), 64'd1);
    check("R7 irq still off", 64'(irq), 64'd0);
    wr(7'h58, 32'd0);
    idle(2);
    check("R8 wake off", 64'(wake), 64'd0);
    wr(7'h44, 32'd1 << 1);
    pin_in[33] = 1'b1;
    idle(4);
    check("R7 irq high word pin 33", 64'(irq), 64'd1);
    wr(7'h54, 32'd1 << 1);
    idle(2);
    check("R7 irq drops after clear", 64'(irq), 64'd0);
    wr(7'h44, 32'd0);

    // R6 collision: clear lands on the capture edge
    wr64(7'h50, 64'hFFFF_FFFF_FFFF_FFFF);
    @(negedge clk);
    pin_in[5] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 5'h14; bus_wdata = 32'd1 << 5;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
    rd64(7'h50, v); check("R6 capture beats clear", v, 64'd1 << 5);
    wr(7'h50, 32'd1 << 5);
    rd64(7'h50, v); check("R6 later clear removes", v, 64'd0);
    check("R10 rdata zero after read", 64'(bus_rdata), 64'd0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule